// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Unit

This unit collects up to 32 interrupt sources into one register-mapped cause vector and drives a single interrupt line toward a processor. Hardware event pulses, or software writes to a set alias, latch cause bits. Each latched bit stays set until software clears it. A mask vector decides which latched causes may reach the interrupt line. Software can read the cause vector either raw or already filtered by the mask.

Each source owns the same bit index in all seven word registers. A per-bit control register chooses how that bit is cleared. With control 0, the bit clears when software writes a 1 to it. With control 1, the bit clears as a side effect of being read. Drivers can therefore mix acknowledge-by-write sources and acknowledge-by-read sources in one bank. The mask can be written whole, or changed one bit at a time through set and clear aliases, so no read-modify-write sequence is needed.

The register port is a plain 32-bit bus with one-cycle read and write strobes and a 3-bit word offset. Read data is combinational and valid in the same cycle as the read strobe. Any clear-on-read side effect takes place at the clock edge that ends that cycle.

Top module: `irq_cause_regs`

## Requirements
- R1: After synchronous reset, the control, cause and mask registers are all zero and `irq_out` is low.
- R2: A one-cycle pulse on `hw_event[n]` sets cause bit n at the next clock edge. The bit then stays set until one of the clear rules below removes it.
- R3: When control bit n is 0, writing 1 to bit n at offset 1 (cause) clears cause bit n. Reading offset 1 leaves it unchanged.
- R4: When control bit n is 1, a read of offset 1 returns the cause value as it was before the clear, then clears every control-1 bit that read as 1. Writes to offset 1 do not change control-1 bits.
- R5: Offset 2 (masked cause) reads as cause AND NOT mask. A read of offset 2 clears only the control-1 bits that it returned as 1. A write of 1 to offset 2 clears only those control-0 bits whose mask bit is 0.
- R6: Writing 1 to bit n at offset 3 (cause set) sets cause bit n. Offset 3 reads as zero.
- R7: Offset 4 (mask) can be read and written directly. Writing 1 to a bit at offset 5 sets that mask bit. Writing 1 to a bit at offset 6 clears that mask bit. Offsets 5, 6 and 7 read as zero.
- R8: `irq_out` is high exactly when at least one cause bit is set while its mask bit is 0. A mask bit of 1 blocks its source.
- R9: When a hardware event and a clear (by write or by read) hit the same cause bit in the same cycle, the event wins and the bit stays set.
- R10: Offset 0 (control) can be read and written, and holds its value between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_addr | input | 3 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| hw_event | input | NUM_SRC | One-cycle event pulses, one per source |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The bench exercises a bank that holds both write-clear and read-clear bits. The same source bits are driven through hardware events, through the set alias, through raw and masked reads, and through raw and masked writes. Reading the same register twice in a row distinguishes read-clear bits from write-clear bits. Pairing a masked read or masked write with a raw read distinguishes "clear only what was seen" from "clear everything". Separate directed cases place an event in the same cycle as each kind of clear, and apply a reset after mask, control and cause bits have been made nonzero.

// File: rtl/irq_cause_pkg.sv
// Shared definitions for the interrupt cause unit: register offsets and
// the one-hot strobe bundle produced by the register decoder.
package irq_cause_pkg;

    localparam int REG_OFS_W = 3;

    typedef enum logic [REG_OFS_W-1:0] {
        OFS_CTRL   = 3'd0,
        OFS_CAUSE  = 3'd1,
        OFS_MASKED = 3'd2,
        OFS_SET    = 3'd3,
        OFS_MASK   = 3'd4,
        OFS_MSET   = 3'd5,
        OFS_MCLR   = 3'd6,
        OFS_SPARE  = 3'd7
    } reg_ofs_e;

    typedef struct packed {
        logic ctrl;
        logic cause;
        logic masked;
        logic set;
        logic mask;
        logic mset;
        logic mclr;
    } reg_sel_t;

endpackage

// File: rtl/irq_reg_decode.sv
// Turns the bus strobes and word offset into one-hot per-register read and
// write selects. Assumes at most one strobe of each kind per cycle.
module irq_reg_decode
    import irq_cause_pkg::*;
(
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_OFS_W-1:0] reg_addr,
    output reg_sel_t             wr_sel,
    output reg_sel_t             rd_sel
);

    reg_sel_t hit;

    // Purpose: map the offset onto a single register select.
    always_comb begin
        hit = '0;
        case (reg_ofs_e'(reg_addr))
            OFS_CTRL:   hit.ctrl   = 1'b1;
            OFS_CAUSE:  hit.cause  = 1'b1;
            OFS_MASKED: hit.masked = 1'b1;
            OFS_SET:    hit.set    = 1'b1;
            OFS_MASK:   hit.mask   = 1'b1;
            OFS_MSET:   hit.mset   = 1'b1;
            OFS_MCLR:   hit.mclr   = 1'b1;
            default:    hit        = '0;
        endcase
    end

    // Purpose: qualify the select with each strobe.
    always_comb begin
        wr_sel = reg_wr ? hit : '0;
        rd_sel = reg_rd ? hit : '0;
    end

    // R7: an access never selects more than one register.
    always_comb begin
        p_sel_onehot_r7: assert ($onehot0(wr_sel) && $onehot0(rd_sel));
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Mask vector with a direct write port and bitwise set and clear aliases.
// Assumes only one of the three write selects is high in any cycle.
module irq_mask_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_direct,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q
);

    // Purpose: update the mask from whichever write port is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_direct)
            mask_q <= wdata;
        else if (wr_set)
            mask_q <= mask_q | wdata;
        else if (wr_clr)
            mask_q <= mask_q & ~wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_chk
            p_mset_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_set && wdata[gi]) |=> mask_q[gi]);
            p_mclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_clr && wdata[gi]) |=> !mask_q[gi]);
        end
    endgenerate

endmodule

// File: rtl/irq_cause_cell.sv
// One cause bit. A hardware event or a software set makes it 1. The clear
// request that applies depends on the bit's mode: write-one-clear when
// cor_mode is 0, clear-on-read when cor_mode is 1. An event always beats a
// clear arriving in the same cycle.
module irq_cause_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic set_req,
    input  logic wclr_req,
    input  logic rclr_req,
    input  logic cor_mode,
    output logic cause_q
);

    logic clr;

    // Purpose: pick the clear source that matches this bit's mode.
    always_comb clr = cor_mode ? rclr_req : wclr_req;

    // Purpose: hold the cause bit; setting beats clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_q <= 1'b0;
        else
            cause_q <= evt | set_req | (cause_q & ~clr);
    end

    p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> cause_q);
    p_cor_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rclr_req && cor_mode && !evt && !set_req) |=> !cause_q);
    p_w1c_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wclr_req && !cor_mode && !evt && !set_req) |=> !cause_q);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q && !wclr_req && !rclr_req) |=> cause_q);

endmodule

// File: rtl/irq_cause_regs.sv
// Register-mapped interrupt cause and mask unit. It provides seven word
// registers (control, cause, masked cause, cause set, mask, mask set,
// mask clear) and one interrupt output. Read data is combinational in the
// strobe cycle, and clear-on-read acts at the end of that cycle.
// Assumes NUM_SRC <= DATA_W.
module irq_cause_regs
    import irq_cause_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_OFS_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_SRC-1:0]   hw_event,
    output logic                 irq_out
);

    localparam int SRC_W = NUM_SRC;

    reg_sel_t            wr_sel;
    reg_sel_t            rd_sel;
    logic [SRC_W-1:0]    wdata_src;
    logic [SRC_W-1:0]    ctrl_q;
    logic [SRC_W-1:0]    cause_q;
    logic [SRC_W-1:0]    mask_q;
    logic [SRC_W-1:0]    pending;
    logic [SRC_W-1:0]    rd_src;

    assign wdata_src = reg_wdata[SRC_W-1:0];

    irq_reg_decode u_decode (
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .wr_sel   (wr_sel),
        .rd_sel   (rd_sel)
    );

    irq_mask_bank #(.WIDTH(SRC_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_direct (wr_sel.mask),
        .wr_set    (wr_sel.mset),
        .wr_clr    (wr_sel.mclr),
        .wdata     (wdata_src),
        .mask_q    (mask_q)
    );

    // Purpose: per-bit clear mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_sel.ctrl)
            ctrl_q <= wdata_src;
    end

    // Purpose: causes that survive the mask.
    always_comb pending = cause_q & ~mask_q;

    genvar gi;
    generate
        for (gi = 0; gi < SRC_W; gi++) begin : g_src
            logic wclr;
            logic rclr;
            // Purpose: clear requests seen by this bit from writes and reads.
            always_comb begin
                wclr = (wr_sel.cause  && wdata_src[gi]) ||
                       (wr_sel.masked && wdata_src[gi] && !mask_q[gi]);
                rclr = (rd_sel.cause  && cause_q[gi]) ||
                       (rd_sel.masked && pending[gi]);
            end
            irq_cause_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (hw_event[gi]),
                .set_req  (wr_sel.set && wdata_src[gi]),
                .wclr_req (wclr),
                .rclr_req (rclr),
                .cor_mode (ctrl_q[gi]),
                .cause_q  (cause_q[gi])
            );
        end
    endgenerate

    // Purpose: read mux; write-only, alias and spare offsets return zero.
    always_comb begin
        rd_src = '0;
        if (rd_sel.ctrl)   rd_src = ctrl_q;
        if (rd_sel.cause)  rd_src = cause_q;
        if (rd_sel.masked) rd_src = pending;
        if (rd_sel.mask)   rd_src = mask_q;
        reg_rdata = '0;
        reg_rdata[SRC_W-1:0] = rd_src;
    end

    // Purpose: aggregate interrupt line.
    always_comb irq_out = |pending;

    p_irq_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel.masked && (reg_rdata != '0)) |-> irq_out);
    p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel.ctrl |=> $stable(ctrl_q));
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel.mask || wr_sel.mset || wr_sel.mclr) |=> $stable(mask_q));

endmodule

// File: tb/irq_cause_regs_bench.sv
module irq_cause_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] hw_event = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_cause_regs u_irq_cause_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hw_event  (hw_event),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [2:0]  addr;
        logic [31:0] wd;
        logic [31:0] ev;
        logic [31:0] exp;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    // Offsets: 0 ctrl, 1 cause, 2 masked, 3 set, 4 mask, 5 mask set, 6 mask clear.
    // irq is checked before the edge of the row; exp only when rd is set.
    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,4'd1},    // R1 cause zero
        '{1'b0,1'b1,3'd0,32'h0,32'h5,32'h0,1'b0,4'd1},    // R1 ctrl zero, event
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h5,1'b1,4'd2},    // R2 latched
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h5,1'b1,4'd3},    // R3 read keeps
        '{1'b1,1'b0,3'd1,32'h1,32'h0,32'h0,1'b1,4'd3},    // R3 w1c bit0
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h4,1'b1,4'd3},
        '{1'b1,1'b0,3'd5,32'h4,32'h0,32'h0,1'b1,4'd7},    // R7 mask set
        '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h0,1'b0,4'd8},    // R8 blocked
        '{1'b0,1'b1,3'd4,32'h0,32'h0,32'h4,1'b0,4'd7},
        '{1'b0,1'b1,3'd5,32'h0,32'h0,32'h0,1'b0,4'd7},    // R7 alias reads 0
        '{1'b1,1'b0,3'd6,32'h4,32'h0,32'h0,1'b0,4'd7},    // R7 mask clear
        '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h4,1'b1,4'd5},
        '{1'b1,1'b0,3'd0,32'hF0,32'h0,32'h0,1'b1,4'd10},  // R10 ctrl write
        '{1'b0,1'b1,3'd0,32'h0,32'h0,32'hF0,1'b1,4'd10},
        '{1'b1,1'b0,3'd3,32'h30,32'h0,32'h0,1'b1,4'd6},   // R6 sw set
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h34,1'b1,4'd4},   // R4 pre-clear value
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h04,1'b1,4'd4},   // R4 cleared
        '{1'b1,1'b0,3'd1,32'h4,32'h0,32'h0,1'b1,4'd3},
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,4'd3},
        '{1'b1,1'b0,3'd5,32'h10,32'h0,32'h0,1'b0,4'd7},
        '{1'b1,1'b0,3'd3,32'h30,32'h0,32'h0,1'b0,4'd6},
        '{1'b0,1'b1,3'd2,32'h0,32'h0,32'h20,1'b1,4'd5},   // R5 masked read
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h10,1'b0,4'd5},   // R5 only seen bit cleared
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,4'd4},
        '{1'b1,1'b0,3'd3,32'h40,32'h0,32'h0,1'b0,4'd6},
        '{1'b1,1'b0,3'd1,32'h40,32'h0,32'h0,1'b1,4'd4},   // R4 write ignored
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h40,1'b1,4'd4},
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,4'd4},
        '{1'b0,1'b1,3'd3,32'h0,32'h0,32'h0,1'b0,4'd6},    // R6 reads 0
        '{1'b0,1'b1,3'd6,32'h0,32'h0,32'h0,1'b0,4'd7},
        '{1'b0,1'b1,3'd7,32'h0,32'h0,32'h0,1'b0,4'd7},
        '{1'b1,1'b0,3'd5,32'h2,32'h0,32'h0,1'b0,4'd7},
        '{1'b0,1'b0,3'd0,32'h0,32'h2,32'h0,1'b0,4'd2},
        '{1'b1,1'b0,3'd2,32'h2,32'h0,32'h0,1'b0,4'd5},    // R5 masked w1c blocked
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h2,1'b0,4'd5},
        '{1'b1,1'b0,3'd4,32'h0,32'h0,32'h0,1'b0,4'd7},    // R7 direct write
        '{1'b0,1'b1,3'd4,32'h0,32'h0,32'h0,1'b1,4'd7},
        '{1'b1,1'b0,3'd2,32'h2,32'h0,32'h0,1'b1,4'd5},    // R5 masked w1c
        '{1'b0,1'b1,3'd1,32'h0,32'h0,32'h0,1'b0,4'd5}
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [2:0] addr,
                         input logic [31:0] wd, input logic [31:0] ev);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd; hw_event = ev;
        #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].rd, VEC[i].addr, VEC[i].wd, VEC[i].ev);
            check(int'(VEC[i].req), "irq", {31'b0, irq_out}, {31'b0, VEC[i].irq});
            if (VEC[i].rd)
                check(int'(VEC[i].req), "rdata", reg_rdata, VEC[i].exp);
        end

        // R9: event on a write-clear bit in the same cycle as its w1c write.
        drive(1'b1, 1'b0, 3'd1, 32'h1, 32'h1);
        drive(1'b0, 1'b1, 3'd1, 32'h0, 32'h0);
        check(9, "event beats w1c", reg_rdata, 32'h1);

        // R9: event on a read-clear bit (bit4) in the same cycle as the read.
        drive(1'b0, 1'b0, 3'd0, 32'h0, 32'h10);
        drive(1'b0, 1'b1, 3'd1, 32'h0, 32'h10);
        check(9, "read with event", reg_rdata, 32'h11);
        drive(1'b0, 1'b1, 3'd1, 32'h0, 32'h0);
        check(9, "event beats read clear", reg_rdata, 32'h11);
        drive(1'b0, 1'b1, 3'd1, 32'h0, 32'h0);
        check(4, "read clear after collision", reg_rdata, 32'h1);

        // R1: reset with mask, control and cause bits nonzero.
        drive(1'b1, 1'b0, 3'd5, 32'h8, 32'h0);
        drive(1'b0, 1'b0, 3'd0, 32'h0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        drive(1'b0, 1'b1, 3'd1, 32'h0, 32'h0);
        check(1, "cause after reset", reg_rdata, 32'h0);
        check(1, "irq after reset", {31'b0, irq_out}, 32'h0);
        drive(1'b0, 1'b1, 3'd0, 32'h0, 32'h0);
        check(1, "ctrl after reset", reg_rdata, 32'h0);
        drive(1'b0, 1'b1, 3'd4, 32'h0, 32'h0);
        check(1, "mask after reset", reg_rdata, 32'h0);
        drive(1'b0, 1'b0, 3'd0, 32'h0, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule